// File: doc/BRIEF.md
# Sideband Thermal-Bus Host Register Front-End

This block is the software-facing register file of a host controller for a single-wire platform sideband bus, the kind used to query processor temperature and configuration. A 32-bit, word-addressed register port holds six configuration fields and a control/status word. It also opens a 64-word window onto a byte buffer, one byte in bits 7:0 of each word. The configuration fields are the target address, the command byte, the transmit and receive byte counts, a two-bit pull-down strength setting and a five-bit host bit-rate value.

Software fills the fields and the transmit bytes, then sets the start bit. The block passes the fields to a separate transaction engine as a one-cycle start pulse. The start bit keeps reading as 1 until the engine reports completion, so software polls it to learn whether the controller is idle. On completion the block records a done flag plus any CRC-error or abort qualifier. The three flags are cleared by writing 1 to them. A level interrupt is raised while the interrupt enable is set and any flag is pending. The engine reads transmit bytes from the buffer and writes received bytes back into it through a side port.

Top module: `sbh_regfront`

## Requirements
- R1: After reset every register, flag and buffer byte reads as zero, `irq` is 0 and `eng_start` is 0.
- R2: The configuration words read back only their fields, with all other bits zero. The fields are receive count bits 6:0 at byte offset 0x04, target address bits 7:0 at 0x08, command bits 7:0 at 0x0C, pull-down bits 7:6 at 0x10, transmit count bits 6:0 at 0x1C and bit-rate bits 4:0 at 0x2C.
- R3: In the control word at 0x00, bit 0 is start/busy. Writing it with 1 while idle sets busy, and one cycle after the write `eng_start` is high for exactly one cycle. Busy stays 1 until the cycle after an `eng_done` pulse, then reads 0.
- R4: A write of 1 to start/busy while busy is set produces no `eng_start` pulse and does not change busy.
- R5: An `eng_done` pulse while busy always sets done (bit 1). CRC error (bit 3) and abort (bit 4) are set from `eng_crc_err` and `eng_abort` in that same cycle. An `eng_done` while idle changes nothing.
- R6: Writing 1 to bit 1, 3 or 4 clears that flag, and writing 0 leaves it unchanged. When the engine sets a flag in the same cycle that software clears it, the flag ends up set.
- R7: Bit 6 of the control word is a read/write interrupt enable. `irq` is high exactly while the enable is 1 and at least one of done, CRC error or abort is 1.
- R8: A bus write at 0x100 + 4*i stores bits 7:0 into buffer byte i (i from 0 to 63). That byte is visible on `eng_buf_rdata` when `eng_buf_idx` is i, and a byte written by the engine at index i reads back in bits 7:0 at that offset.
- R9: Reads of unmapped offsets return zero, and writes to them change no register.
- R10: The engine-side field outputs always present the currently programmed configuration values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_tgt | output | 8 | Target address |
| eng_cmd | output | 8 | Command byte |
| eng_wr_len | output | 7 | Transmit byte count |
| eng_rd_len | output | 7 | Receive byte count |
| eng_pull | output | 2 | Pull-down strength setting |
| eng_rate | output | 5 | Host bit-rate value |
| eng_buf_idx | input | 6 | Engine buffer byte index |
| eng_buf_rdata | output | 8 | Buffer byte at eng_buf_idx |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_wdata | input | 8 | Engine buffer write byte |
| eng_done | input | 1 | One-cycle completion pulse |
| eng_crc_err | input | 1 | CRC-error qualifier, valid with eng_done |
| eng_abort | input | 1 | Abort qualifier, valid with eng_done |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume that the engine raises `eng_done` only as a single-cycle pulse and that its qualifiers count only in that cycle. The stimulus keeps to this by driving done from one task that holds it high for exactly one clock. It also pulses done once while idle, to show that a stray completion is dropped. No property assumes anything about the timing of bus writes. The stimulus therefore includes a start written during busy and a flag clear that lands on the same edge as a completion.

// File: rtl/sbh_pkg.sv
package sbh_pkg;

  localparam int LEN_W  = 7;
  localparam int PULL_W = 2;
  localparam int RATE_W = 5;

  // word indices (byte offset / 4)
  localparam int W_CTL   = 0;
  localparam int W_RXLEN = 1;
  localparam int W_TGT   = 2;
  localparam int W_CMD   = 3;
  localparam int W_CTL2  = 4;
  localparam int W_TXLEN = 7;
  localparam int W_RATE  = 11;
  localparam int W_DATA  = 64;

  // control word bit positions
  localparam int B_START = 0;
  localparam int B_DONE  = 1;
  localparam int B_CRC   = 3;
  localparam int B_ABORT = 4;
  localparam int B_IEN   = 6;
  localparam int B_PULL  = 6;

  typedef struct packed {
    logic [7:0]        tgt;
    logic [7:0]        cmd;
    logic [LEN_W-1:0]  tx_len;
    logic [LEN_W-1:0]  rx_len;
    logic [PULL_W-1:0] pull;
    logic [RATE_W-1:0] rate;
  } sbh_cfg_t;

  function automatic logic irq_level(input logic en, input logic done,
                                     input logic crc, input logic abrt);
    return en & (done | crc | abrt);
  endfunction

  function automatic logic [31:0] ctl_word(input logic busy, input logic done,
                                           input logic crc, input logic abrt,
                                           input logic en);
    logic [31:0] w;
    w = '0;
    w[B_START] = busy;
    w[B_DONE]  = done;
    w[B_CRC]   = crc;
    w[B_ABORT] = abrt;
    w[B_IEN]   = en;
    return w;
  endfunction

  // next value of a write-one-to-clear flag; a set event wins
  function automatic logic w1c_next(input logic cur, input logic set,
                                    input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/sbh_ctl.sv
module sbh_ctl
  import sbh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_wdata,
  input  logic        eng_done,
  input  logic        eng_crc_err,
  input  logic        eng_abort,
  output logic        busy,
  output logic        done,
  output logic        crc,
  output logic        abrt,
  output logic        ien,
  output logic        start_pulse,
  output logic        launch,
  output logic        finish,
  output logic        irq
);

  logic busy_q, done_q, crc_q, abrt_q, ien_q, start_q;

  assign launch = ctl_we & ctl_wdata[B_START] & ~busy_q;
  assign finish = eng_done & busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      crc_q   <= 1'b0;
      abrt_q  <= 1'b0;
      ien_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= launch;
      if (launch)      busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      done_q <= w1c_next(done_q, finish,
                         ctl_we & ctl_wdata[B_DONE]);
      crc_q  <= w1c_next(crc_q, finish & eng_crc_err,
                         ctl_we & ctl_wdata[B_CRC]);
      abrt_q <= w1c_next(abrt_q, finish & eng_abort,
                         ctl_we & ctl_wdata[B_ABORT]);
      if (ctl_we) ien_q <= ctl_wdata[B_IEN];
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign crc         = crc_q;
  assign abrt        = abrt_q;
  assign ien         = ien_q;
  assign start_pulse = start_q;
  assign irq         = irq_level(ien_q, done_q, crc_q, abrt_q);

endmodule

// File: rtl/sbh_cfg.sv
module sbh_cfg
  import sbh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_rxlen,
  input  logic        we_tgt,
  input  logic        we_cmd,
  input  logic        we_ctl2,
  input  logic        we_txlen,
  input  logic        we_rate,
  input  logic [7:0]  wdata,
  output sbh_cfg_t    cfg
);

  sbh_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      if (we_rxlen) cfg_q.rx_len <= wdata[LEN_W-1:0];
      if (we_tgt)   cfg_q.tgt    <= wdata;
      if (we_cmd)   cfg_q.cmd    <= wdata;
      if (we_ctl2)  cfg_q.pull   <= wdata[B_PULL +: PULL_W];
      if (we_txlen) cfg_q.tx_len <= wdata[LEN_W-1:0];
      if (we_rate)  cfg_q.rate   <= wdata[RATE_W-1:0];
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/sbh_buf.sv
module sbh_buf #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [7:0]       bus_wbyte,
  output logic [7:0]       bus_rbyte,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic [7:0]       eng_wbyte,
  output logic [7:0]       eng_rbyte
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      // the engine side wins a same-index collision
      if (bus_we && !(eng_we && eng_idx == bus_idx)) mem[bus_idx] <= bus_wbyte;
      if (eng_we) mem[eng_idx] <= eng_wbyte;
    end
  end

  assign bus_rbyte = mem[bus_idx];
  assign eng_rbyte = mem[eng_idx];

endmodule

// File: rtl/sbh_regfront.sv
module sbh_regfront
  import sbh_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BUF_DEPTH = 64,
  localparam int IDX_W    = $clog2(BUF_DEPTH),
  localparam int WORD_W   = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              eng_start,
  output logic [7:0]        eng_tgt,
  output logic [7:0]        eng_cmd,
  output logic [LEN_W-1:0]  eng_wr_len,
  output logic [LEN_W-1:0]  eng_rd_len,
  output logic [PULL_W-1:0] eng_pull,
  output logic [RATE_W-1:0] eng_rate,
  input  logic [IDX_W-1:0]  eng_buf_idx,
  output logic [7:0]        eng_buf_rdata,
  input  logic              eng_buf_we,
  input  logic [7:0]        eng_buf_wdata,
  input  logic              eng_done,
  input  logic              eng_crc_err,
  input  logic              eng_abort,
  output logic              irq
);

  logic [WORD_W-1:0] word;
  logic              in_buf;
  logic [IDX_W-1:0]  buf_idx;
  logic              sel_ctl, sel_rxlen, sel_tgt, sel_cmd, sel_ctl2, sel_txlen, sel_rate;
  logic              busy, done, crc, abrt, ien, launch, finish;
  logic [7:0]        buf_rbyte;
  sbh_cfg_t          cfg;
  logic              unused_bits;

  assign word      = bus_addr[ADDR_W-1:2];
  assign in_buf    = (int'(word) >= W_DATA) && (int'(word) < W_DATA + BUF_DEPTH);
  assign buf_idx   = IDX_W'(int'(word) - W_DATA);
  assign sel_ctl   = int'(word) == W_CTL;
  assign sel_rxlen = int'(word) == W_RXLEN;
  assign sel_tgt   = int'(word) == W_TGT;
  assign sel_cmd   = int'(word) == W_CMD;
  assign sel_ctl2  = int'(word) == W_CTL2;
  assign sel_txlen = int'(word) == W_TXLEN;
  assign sel_rate  = int'(word) == W_RATE;
  assign unused_bits = ^{bus_wdata[31:8], bus_addr[1:0]};

  sbh_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (bus_wr & sel_ctl),
    .ctl_wdata   (bus_wdata[7:0]),
    .eng_done    (eng_done),
    .eng_crc_err (eng_crc_err),
    .eng_abort   (eng_abort),
    .busy        (busy),
    .done        (done),
    .crc         (crc),
    .abrt        (abrt),
    .ien         (ien),
    .start_pulse (eng_start),
    .launch      (launch),
    .finish      (finish),
    .irq         (irq)
  );

  sbh_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_rxlen (bus_wr & sel_rxlen),
    .we_tgt   (bus_wr & sel_tgt),
    .we_cmd   (bus_wr & sel_cmd),
    .we_ctl2  (bus_wr & sel_ctl2),
    .we_txlen (bus_wr & sel_txlen),
    .we_rate  (bus_wr & sel_rate),
    .wdata    (bus_wdata[7:0]),
    .cfg      (cfg)
  );

  sbh_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_wr & in_buf),
    .bus_idx   (buf_idx),
    .bus_wbyte (bus_wdata[7:0]),
    .bus_rbyte (buf_rbyte),
    .eng_we    (eng_buf_we),
    .eng_idx   (eng_buf_idx),
    .eng_wbyte (eng_buf_wdata),
    .eng_rbyte (eng_buf_rdata)
  );

  assign eng_tgt    = cfg.tgt;
  assign eng_cmd    = cfg.cmd;
  assign eng_wr_len = cfg.tx_len;
  assign eng_rd_len = cfg.rx_len;
  assign eng_pull   = cfg.pull;
  assign eng_rate   = cfg.rate;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (in_buf)         bus_rdata[7:0] = buf_rbyte;
      else if (sel_ctl)   bus_rdata = ctl_word(busy, done, crc, abrt, ien);
      else if (sel_rxlen) bus_rdata[LEN_W-1:0] = cfg.rx_len;
      else if (sel_tgt)   bus_rdata[7:0] = cfg.tgt;
      else if (sel_cmd)   bus_rdata[7:0] = cfg.cmd;
      else if (sel_ctl2)  bus_rdata[B_PULL +: PULL_W] = cfg.pull;
      else if (sel_txlen) bus_rdata[LEN_W-1:0] = cfg.tx_len;
      else if (sel_rate)  bus_rdata[RATE_W-1:0] = cfg.rate;
    end
  end

endmodule

// File: rtl/sbh_regfront_chk.sv
module sbh_regfront_chk (
  input logic clk,
  input logic rst_n,
  input logic eng_start,
  input logic eng_done,
  input logic busy,
  input logic done,
  input logic ien,
  input logic launch,
  input logic finish,
  input logic irq
);

  // R3
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $rose(busy));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done) |=> busy);

  // R4
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);

  // R5
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !busy));

  // R7
  irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ien) |-> irq);

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

endmodule

bind sbh_regfront sbh_regfront_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .eng_start (eng_start),
  .eng_done  (eng_done),
  .busy      (busy),
  .done      (done),
  .ien       (ien),
  .launch    (launch),
  .finish    (finish),
  .irq       (irq)
);

// File: tb/sbh_regfront_test.sv
module sbh_regfront_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_start;
  logic [7:0]  eng_tgt, eng_cmd;
  logic [6:0]  eng_wr_len, eng_rd_len;
  logic [1:0]  eng_pull;
  logic [4:0]  eng_rate;
  logic [5:0]  eng_buf_idx = '0;
  logic [7:0]  eng_buf_rdata;
  logic        eng_buf_we = 1'b0;
  logic [7:0]  eng_buf_wdata = '0;
  logic        eng_done = 1'b0, eng_crc_err = 1'b0, eng_abort = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int starts = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sbh_regfront uut (.*);

  // behavioural reference of the control word
  bit m_busy, m_done, m_crc, m_abort, m_en, m_start;

  always @(posedge clk) begin
    bit fin, go;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_crc = 0; m_abort = 0; m_en = 0; m_start = 0;
    end else begin
      fin = eng_done && m_busy;
      go  = bus_wr && bus_addr == 10'h000 && bus_wdata[0] && !m_busy;
      m_start = go;
      if (bus_wr && bus_addr == 10'h000) begin
        if (bus_wdata[1]) m_done = 0;
        if (bus_wdata[3]) m_crc = 0;
        if (bus_wdata[4]) m_abort = 0;
        m_en = bus_wdata[6];
      end
      if (fin) begin
        m_busy = 0;
        m_done = 1;
        if (eng_crc_err) m_crc = 1;
        if (eng_abort) m_abort = 1;
      end
      if (go) m_busy = 1;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    bit exp_irq;
    cycles++;
    if (eng_start) starts++;
    if (rst_n) begin
      exp_irq = m_en && (m_done || m_crc || m_abort);
      checks++;
      if (irq !== exp_irq) begin
        errors++;
        $display("FAIL R7 irq actual=%0b expected=%0b", irq, exp_irq);
      end
      checks++;
      if (eng_start !== m_start) begin
        errors++;
        $display("FAIL R3/R4 eng_start actual=%0b expected=%0b", eng_start, m_start);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #2 v = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_reg(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic finish_eng(input bit c, input bit ab);
    @(negedge clk);
    eng_done = 1; eng_crc_err = c; eng_abort = ab;
    @(negedge clk);
    eng_done = 0; eng_crc_err = 0; eng_abort = 0;
  endtask

  initial begin
    int s0;
    logic [9:0] cfg_offs [6] = '{10'h04, 10'h08, 10'h0C, 10'h10, 10'h1C, 10'h2C};
    logic [31:0] cfg_mask [6] = '{32'h7F, 32'hFF, 32'hFF, 32'hC0, 32'h7F, 32'h1F};
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset values
    for (int k = 0; k < 6; k++) expect_reg("R1 cfg reset", cfg_offs[k], 0);
    expect_reg("R1 ctl reset", 10'h000, 0);
    expect_reg("R1 buf reset", 10'h100, 0);
    chk("R1 irq reset", {31'b0, irq}, 0);
    chk("R1 start reset", {31'b0, eng_start}, 0);

    // R2: field masks
    for (int k = 0; k < 6; k++) begin
      wr(cfg_offs[k], 32'hFFFF_FFFF);
      expect_reg("R2 mask", cfg_offs[k], cfg_mask[k]);
    end

    // R10: programmed values on the engine side
    wr(10'h08, 32'h30); wr(10'h0C, 32'hA1); wr(10'h1C, 32'h3);
    wr(10'h04, 32'h5);  wr(10'h10, 32'h40); wr(10'h2C, 32'hF);
    @(negedge clk);
    chk("R10 fields", {eng_tgt, eng_cmd, 1'b0, eng_wr_len, 1'b0, eng_rd_len},
        {8'h30, 8'hA1, 8'h03, 8'h05});
    chk("R10 pull/rate", {eng_pull, eng_rate}, {2'b01, 5'd15});

    // R8: buffer window from the bus side
    wr(10'h100, 32'h1234_56AB);
    wr(10'h1FC, 32'hFFFF_FF5C);
    expect_reg("R8 buf word0", 10'h100, 32'hAB);
    expect_reg("R8 buf word63", 10'h1FC, 32'h5C);
    eng_buf_idx = 6'd0;  #1 chk("R8 eng read 0", {24'b0, eng_buf_rdata}, 32'hAB);
    eng_buf_idx = 6'd63; #1 chk("R8 eng read 63", {24'b0, eng_buf_rdata}, 32'h5C);

    // R9: unmapped offsets
    wr(10'h014, 32'hFF); wr(10'h018, 32'hFF); wr(10'h200, 32'hFF); wr(10'h3FC, 32'hFF);
    expect_reg("R9 read 0x14", 10'h014, 0);
    expect_reg("R9 read 0x200", 10'h200, 0);
    expect_reg("R9 read 0x3FC", 10'h3FC, 0);
    expect_reg("R9 tgt intact", 10'h08, 32'h30);
    expect_reg("R9 rate intact", 10'h2C, 32'hF);
    expect_reg("R9 ctl intact", 10'h000, 0);

    // R3 / R4: launch, busy, ignored relaunch
    s0 = starts;
    wr(10'h000, 32'h41);
    expect_reg("R3 busy set", 10'h000, 32'h41);
    wr(10'h000, 32'h41);
    expect_reg("R4 busy unchanged", 10'h000, 32'h41);
    chk("R4 one start", starts - s0, 1);
    @(negedge clk);
    eng_buf_we = 1; eng_buf_idx = 6'd0; eng_buf_wdata = 8'h77;
    @(negedge clk);
    eng_buf_idx = 6'd1; eng_buf_wdata = 8'h88;
    @(negedge clk);
    eng_buf_we = 0;
    finish_eng(0, 0);
    expect_reg("R3 busy cleared, R5 done", 10'h000, 32'h42);
    chk("R7 irq on done", {31'b0, irq}, 1);
    expect_reg("R8 engine byte 0", 10'h100, 32'h77);
    expect_reg("R8 engine byte 1", 10'h104, 32'h88);

    // R6: writing zero keeps, writing one clears
    wr(10'h000, 32'h40);
    expect_reg("R6 zero keeps", 10'h000, 32'h42);
    wr(10'h000, 32'h42);
    expect_reg("R6 one clears", 10'h000, 32'h40);
    chk("R7 irq dropped", {31'b0, irq}, 0);

    // R5: done set alongside CRC error
    wr(10'h000, 32'h41);
    finish_eng(1, 0);
    expect_reg("R5 done with crc", 10'h000, 32'h4A);
    wr(10'h000, 32'h48);
    expect_reg("R6 crc only cleared", 10'h000, 32'h42);
    wr(10'h000, 32'h42);

    // R7: abort with the enable off, then on
    wr(10'h000, 32'h01);
    finish_eng(0, 1);
    expect_reg("R5 done with abort", 10'h000, 32'h12);
    chk("R7 masked", {31'b0, irq}, 0);
    wr(10'h000, 32'h40);
    chk("R7 unmasked", {31'b0, irq}, 1);
    wr(10'h000, 32'h52);
    expect_reg("R6 all cleared", 10'h000, 32'h40);

    // R6: set wins over a clear on the same edge
    wr(10'h000, 32'h41);
    @(negedge clk);
    bus_wr = 1; bus_addr = 10'h000; bus_wdata = 32'h42; eng_done = 1;
    @(negedge clk);
    bus_wr = 0; eng_done = 0;
    expect_reg("R6 set wins", 10'h000, 32'h42);
    wr(10'h000, 32'h42);

    // R5: completion while idle is dropped
    finish_eng(1, 1);
    expect_reg("R5 idle done ignored", 10'h000, 32'h40);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule